// File: doc/BRIEF.md
# Bus Monitor and Access Guard

This block sits beside the processor on a 68000-style asynchronous bus and watches every bus cycle. It times each cycle from the assertion of the address strobe. If the slave never returns its acknowledge within a programmable number of clocks, it raises a bus error. At the start of each cycle it also checks two attributes that the caller supplies for the addressed region. A write to a write-protected region, or a user-mode access to a supervisor-only region, raises the bus error for that cycle.

Each of the three fault kinds latches a sticky status flag. Software clears a flag by writing a one to it. The same 8-bit control and status register holds the enables. It is decoded at a fixed offset inside a 4 KB window at the top of the 32-bit space. When the alias-enable bit is set, the register also answers at a second copy of that window at the top of the 24-bit space.

The bus signals are plain level inputs sampled on the block clock. A bus cycle is a run of clocks with the strobe high, and no valid/ready flow control applies. The block never stalls the bus. It only answers with a bus error, read data and a register-select flag.

Top module: `bus_guard`

## Requirements
- R1: After reset the register reads 0x40: alias enable (bit 6) is 1 and all other bits are 0. `berr` and all status flags are 0.
- R2: While timeout enable (bit 4) is 1, a cycle that has not seen `bus_dtack` by its TERM_CNT-th strobe-high clock raises `berr` right after that clock and sets the timeout flag (bit 0). If `bus_dtack` is seen by that clock, the cycle raises no timeout error.
- R3: While timeout enable is 0, no cycle raises a timeout error or sets the timeout flag, however long the strobe stays high.
- R4: The first clock of a write cycle (`bus_rnw`=0) with `region_wp`=1 sets the write-protect flag (bit 1) and raises `berr` for that cycle. Read cycles never set it.
- R5: The first clock of a user cycle (`bus_super`=0) with `region_so`=1 sets the privilege flag (bit 2) and raises `berr`. Supervisor cycles never set it.
- R6: While supervisor-only (bit 5) is 1, a user access to the register is a privilege violation: it sets bit 2, raises `berr`, and its write is discarded. Supervisor accesses, and user accesses while bit 5 is 0, write normally.
- R7: Writing 1 to a flag bit (0, 1 or 2) clears that flag. Writing 0 leaves it unchanged.
- R8: If a flag's set event and a write-1 to the same flag happen on the same clock, the flag ends up set.
- R9: The register is selected when the strobe is high, the address offset within the window equals REG_OFS (default 0), and either address bits [31:12] are all ones, or alias enable is 1 with bits [31:24] zero and bits [23:12] all ones.
- R10: Bit 3 is reserved and always reads 0, even after a write of 1.
- R11: `width8_sel` always equals register bit 7, which software writes.
- R12: `berr` falls on the first clock with the strobe low. The timer restarts from zero on every new cycle, so cycles shorter than TERM_CNT clocks never time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_as | input | 1 | Address strobe, high for the length of a bus cycle |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_super | input | 1 | 1 = supervisor cycle, 0 = user cycle |
| bus_addr | input | ADDR_W | Cycle address |
| bus_dtack | input | 1 | Slave acknowledge |
| region_wp | input | 1 | Addressed region is write-protected |
| region_so | input | 1 | Addressed region is supervisor-only |
| bus_wdata | input | 8 | Write data for the register |
| bus_rdata | output | 8 | Register read data |
| reg_sel | output | 1 | Register is addressed by the current cycle |
| berr | output | 1 | Bus error for the current cycle |
| stat_tmo | output | 1 | Sticky timeout flag |
| stat_wp | output | 1 | Sticky write-protect flag |
| stat_priv | output | 1 | Sticky privilege flag |
| width8_sel | output | 1 | 8-bit system select |

## Verification
The assertions assume the following about the inputs:
- Between two cycles the strobe drops for at least one clock.
- Address, direction, mode, region attributes and write data hold steady from the strobe's first clock.

The bench follows these rules. It drives every input on the falling edge, leaves an idle clock after each cycle, and keeps each cycle's attributes constant from its first clock.

The bench builds the design with a terminal count of 8. This keeps a sweep of every acknowledge arrival position short. The region attribute sweep also covers every combination of direction, mode and the two attributes.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned B_TMO    = 0;
  localparam int unsigned B_WP     = 1;
  localparam int unsigned B_PRIV   = 2;
  localparam int unsigned B_RSVD   = 3;
  localparam int unsigned B_TEN    = 4;
  localparam int unsigned B_SONLY  = 5;
  localparam int unsigned B_ALIAS  = 6;
  localparam int unsigned B_WIDTH8 = 7;

  typedef struct packed {
    logic width8;
    logic alias_en;
    logic sup_only;
    logic tmo_en;
  } ctl_t;

  typedef struct packed {
    logic priv;
    logic wp;
    logic tmo;
  } flags_t;

  localparam ctl_t CTL_RESET = '{width8: 1'b0, alias_en: 1'b1, sup_only: 1'b0, tmo_en: 1'b0};
endpackage

// File: rtl/bg_addr_decode.sv
module bg_addr_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 12,
  parameter logic [WIN_BITS-1:0] REG_OFS = '0
) (
  input  logic              as_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              alias_en_i,
  output logic              reg_sel_o
);
  localparam int unsigned ALIAS_TOP = 24;
  localparam int unsigned HI_W      = ADDR_W - ALIAS_TOP;

  logic prim_hit;
  logic alias_hit;
  logic ofs_hit;

  always_comb begin
    prim_hit  = &addr_i[ADDR_W-1:WIN_BITS];
    alias_hit = alias_en_i
              && (addr_i[ADDR_W-1:ALIAS_TOP] == {HI_W{1'b0}})
              && (&addr_i[ALIAS_TOP-1:WIN_BITS]);
    ofs_hit   = (addr_i[WIN_BITS-1:0] == REG_OFS);
    reg_sel_o = as_i && ofs_hit && (prim_hit || alias_hit);
  end
endmodule

// File: rtl/bg_bus_timer.sv
module bg_bus_timer #(
  parameter int unsigned TERM_CNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_i,
  input  logic dtack_i,
  input  logic enable_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TERM_CNT + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TERM_CNT - 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TERM_CNT);

  logic [CNT_W-1:0] cnt_q;
  logic             ack_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ack_seen_q <= 1'b0;
    end else if (!as_i) begin
      cnt_q      <= '0;
      ack_seen_q <= 1'b0;
    end else begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (dtack_i) ack_seen_q <= 1'b1;
    end
  end

  always_comb begin
    expire_o = as_i && enable_i && !ack_seen_q && !dtack_i && (cnt_q == LAST);
  end
endmodule

// File: rtl/bg_access_check.sv
module bg_access_check (
  input  logic start_i,
  input  logic rnw_i,
  input  logic super_i,
  input  logic region_wp_i,
  input  logic region_so_i,
  input  logic reg_sel_i,
  input  logic sup_only_i,
  output logic wp_set_o,
  output logic priv_set_o,
  output logic reg_wr_o
);
  logic user_reg_block;

  always_comb begin
    user_reg_block = reg_sel_i && sup_only_i && !super_i;
    wp_set_o       = start_i && !rnw_i && region_wp_i;
    priv_set_o     = start_i && !super_i && (region_so_i || user_reg_block);
    reg_wr_o       = start_i && reg_sel_i && !rnw_i && !priv_set_o;
  end
endmodule

// File: rtl/bg_csr.sv
module bg_csr
  import bg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  flags_t           set_i,
  output ctl_t             ctl_o,
  output flags_t           flags_o,
  output logic [CSR_W-1:0] rdata_o
);
  flags_t flags_q;
  ctl_t   ctl_q;
  flags_t clr;

  always_comb begin
    clr = '0;
    if (wr_i) begin
      clr.tmo  = wdata_i[B_TMO];
      clr.wp   = wdata_i[B_WP];
      clr.priv = wdata_i[B_PRIV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctl_q   <= CTL_RESET;
    end else begin
      flags_q <= (flags_q & ~clr) | set_i;
      if (wr_i) begin
        ctl_q.tmo_en   <= wdata_i[B_TEN];
        ctl_q.sup_only <= wdata_i[B_SONLY];
        ctl_q.alias_en <= wdata_i[B_ALIAS];
        ctl_q.width8   <= wdata_i[B_WIDTH8];
      end
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[B_TMO]    = flags_q.tmo;
    rdata_o[B_WP]     = flags_q.wp;
    rdata_o[B_PRIV]   = flags_q.priv;
    rdata_o[B_RSVD]   = 1'b0;
    rdata_o[B_TEN]    = ctl_q.tmo_en;
    rdata_o[B_SONLY]  = ctl_q.sup_only;
    rdata_o[B_ALIAS]  = ctl_q.alias_en;
    rdata_o[B_WIDTH8] = ctl_q.width8;
  end

  assign ctl_o   = ctl_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/bus_guard.sv
module bus_guard
  import bg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 12,
  parameter logic [WIN_BITS-1:0] REG_OFS = '0,
  parameter int unsigned TERM_CNT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as,
  input  logic              bus_rnw,
  input  logic              bus_super,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dtack,
  input  logic              region_wp,
  input  logic              region_so,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reg_sel,
  output logic              berr,
  output logic              stat_tmo,
  output logic              stat_wp,
  output logic              stat_priv,
  output logic              width8_sel
);
  logic   as_q;
  logic   start;
  logic   expire;
  logic   wp_set;
  logic   priv_set;
  logic   reg_wr;
  logic   berr_q;
  ctl_t   ctl;
  flags_t flags;
  flags_t set_ev;
  logic   tmo_en;
  logic   dmap_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) as_q <= 1'b0;
    else        as_q <= bus_as;
  end

  assign start   = bus_as && !as_q;
  assign tmo_en  = ctl.tmo_en;
  assign dmap_on = ctl.alias_en;

  bg_addr_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .REG_OFS(REG_OFS)) u_dec (
    .as_i(bus_as), .addr_i(bus_addr), .alias_en_i(dmap_on), .reg_sel_o(reg_sel)
  );

  bg_bus_timer #(.TERM_CNT(TERM_CNT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .as_i(bus_as), .dtack_i(bus_dtack),
    .enable_i(tmo_en), .expire_o(expire)
  );

  bg_access_check u_chk (
    .start_i(start), .rnw_i(bus_rnw), .super_i(bus_super),
    .region_wp_i(region_wp), .region_so_i(region_so), .reg_sel_i(reg_sel),
    .sup_only_i(ctl.sup_only), .wp_set_o(wp_set), .priv_set_o(priv_set),
    .reg_wr_o(reg_wr)
  );

  always_comb begin
    set_ev      = '0;
    set_ev.tmo  = expire;
    set_ev.wp   = wp_set;
    set_ev.priv = priv_set;
  end

  bg_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .wdata_i(bus_wdata),
    .set_i(set_ev), .ctl_o(ctl), .flags_o(flags), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           berr_q <= 1'b0;
    else if (!bus_as)                     berr_q <= 1'b0;
    else if (expire || wp_set || priv_set) berr_q <= 1'b1;
  end

  assign berr       = berr_q;
  assign stat_tmo   = flags.tmo;
  assign stat_wp    = flags.wp;
  assign stat_priv  = flags.priv;
  assign width8_sel = ctl.width8;
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as,
  input logic              bus_rnw,
  input logic              bus_super,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_dtack,
  input logic              region_wp,
  input logic [7:0]        bus_wdata,
  input logic              reg_sel,
  input logic              berr,
  input logic              stat_tmo,
  input logic              stat_wp,
  input logic              stat_priv,
  input logic              tmo_en,
  input logic              dmap_on
);
  a_r12_berr_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as |=> !berr);

  a_r2_tmo_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_tmo) |-> $past(bus_as && !bus_dtack));

  a_r3_tmo_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_tmo) |-> $past(tmo_en));

  a_r4_wp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_wp) |-> $past(bus_as && !bus_rnw && region_wp));

  a_r5_priv_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_priv) |-> $past(bus_as && !bus_super));

  a_r7_wp_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_wp) |-> $past(reg_sel && !bus_rnw && bus_wdata[1]));

  a_r9_alias_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && bus_addr[ADDR_W-1:24] == '0) |-> dmap_on);
endmodule

bind bus_guard bg_checker #(.ADDR_W(ADDR_W)) u_bg_checker (
  .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_rnw(bus_rnw),
  .bus_super(bus_super), .bus_addr(bus_addr), .bus_dtack(bus_dtack),
  .region_wp(region_wp), .bus_wdata(bus_wdata), .reg_sel(reg_sel),
  .berr(berr), .stat_tmo(stat_tmo), .stat_wp(stat_wp), .stat_priv(stat_priv),
  .tmo_en(tmo_en), .dmap_on(dmap_on)
);

// File: tb/tb_bus_guard.sv
`timescale 1ns/1ps
module tb_bus_guard;
  localparam int TERM = 8;
  localparam logic [31:0] PRIM = 32'hFFFF_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_i = 0, rnw = 1, sup = 1, dtack = 0, wp = 0, so = 0;
  logic [31:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sel, berr, s_tmo, s_wp, s_priv, w8;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model of the register
  logic m_ten = 0, m_so = 0, m_alias = 1, m_w8 = 0;
  logic m_tmo = 0, m_wp = 0, m_priv = 0;

  always #4 clk = ~clk;

  bus_guard #(.TERM_CNT(TERM)) dut (
    .clk(clk), .rst_n(rst_n), .bus_as(as_i), .bus_rnw(rnw), .bus_super(sup),
    .bus_addr(addr), .bus_dtack(dtack), .region_wp(wp), .region_so(so),
    .bus_wdata(wdata), .bus_rdata(rdata), .reg_sel(sel), .berr(berr),
    .stat_tmo(s_tmo), .stat_wp(s_wp), .stat_priv(s_priv), .width8_sel(w8)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mdl(input logic [2:0] clr);
    return {m_w8, m_alias, m_so, m_ten, 1'b0, clr};
  endfunction

  function automatic logic [7:0] mread();
    return {m_w8, m_alias, m_so, m_ten, 1'b0, m_priv, m_wp, m_tmo};
  endfunction

  // one-clock acknowledged cycle; results sampled after the first edge
  task automatic access(input logic [31:0] a, input logic r, input logic s,
                        input logic pw, input logic ps, input logic [7:0] d,
                        output logic b, output logic [7:0] rd, output logic sl);
    @(negedge clk);
    addr = a; rnw = r; sup = s; wp = pw; so = ps; wdata = d; dtack = 1; as_i = 1;
    @(negedge clk);
    b = berr; rd = rdata; sl = sel;
    as_i = 0; dtack = 0; wp = 0; so = 0;
    @(negedge clk);
  endtask

  task automatic csr_wr(input logic [7:0] d);
    logic b; logic [7:0] rd; logic sl;
    access(PRIM, 1'b0, 1'b1, 1'b0, 1'b0, d, b, rd, sl);
    m_ten = d[4]; m_so = d[5]; m_alias = d[6]; m_w8 = d[7];
    if (d[0]) m_tmo = 0;
    if (d[1]) m_wp = 0;
    if (d[2]) m_priv = 0;
  endtask

  task automatic csr_rd(output logic [7:0] v);
    logic b; logic sl;
    access(PRIM, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, b, v, sl);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic b; logic [7:0] rd; logic sl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 berr", berr, 0);
    chk("R1 flags", {s_priv, s_wp, s_tmo}, 0);
    csr_rd(rd);
    chk("R1 reset value", rd, 8'h40);

    // R9 decode sweep, alias on then off
    for (int al = 1; al >= 0; al--) begin
      m_alias = al[0];
      csr_wr(mdl(3'b000));
      for (int bi = 0; bi < 6; bi++) begin
        for (int oi = 0; oi < 2; oi++) begin
          logic [31:0] base, a;
          logic prim, alh, exp;
          case (bi)
            0: base = 32'hFFFF_F000;
            1: base = 32'h00FF_F000;
            2: base = 32'hFFFF_E000;
            3: base = 32'h00FF_E000;
            4: base = 32'h01FF_F000;
            default: base = 32'h0000_1000;
          endcase
          a = base + 32'(oi * 4);
          prim = (a[31:12] == 20'hFFFFF);
          alh  = al[0] && (a[31:24] == 8'h00) && (a[23:12] == 12'hFFF);
          exp  = (a[11:0] == 12'h000) && (prim || alh);
          access(a, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, b, rd, sl);
          chk("R9 select", sl, exp);
        end
      end
    end
    m_alias = 1;
    csr_wr(mdl(3'b000));

    // R2 timeout sweep over acknowledge arrival position
    m_ten = 1;
    csr_wr(mdl(3'b000));
    for (int d = 0; d <= TERM + 1; d++) begin
      @(negedge clk);
      addr = 32'h0000_1000; rnw = 1; sup = 1; as_i = 1; dtack = (d == 0);
      for (int i = 0; i <= TERM + 1; i++) begin
        @(negedge clk);
        chk("R2 berr timing", berr, (d >= TERM) && (i >= TERM - 1));
        dtack = (i + 1 >= d);
      end
      chk("R2 timeout flag", s_tmo, d >= TERM);
      as_i = 0; dtack = 0;
      @(negedge clk);
      chk("R12 berr falls", berr, 0);
      if (d >= TERM) m_tmo = 1;
      // R7 write-0 keeps, write-1 clears
      csr_wr(mdl(3'b000));
      chk("R7 write 0 keeps", s_tmo, m_tmo);
      csr_wr(mdl(3'b001));
      chk("R7 write 1 clears", s_tmo, 0);
    end

    // R12 back-to-back short cycles do not accumulate
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      addr = 32'h0000_1000; rnw = 1; sup = 1; as_i = 1; dtack = 0;
      repeat (TERM - 1) @(negedge clk);
      chk("R12 no timeout short cycle", berr, 0);
      as_i = 0;
      @(negedge clk);
    end
    chk("R12 timer restart flag", s_tmo, 0);

    // R3 timeout disabled
    m_ten = 0;
    csr_wr(mdl(3'b000));
    @(negedge clk);
    addr = 32'h0000_1000; rnw = 1; sup = 1; as_i = 1; dtack = 0;
    repeat (TERM + 4) @(negedge clk);
    chk("R3 no berr when disabled", berr, 0);
    as_i = 0;
    @(negedge clk);
    chk("R3 no flag when disabled", s_tmo, 0);

    // R4 and R5 attribute sweep
    for (int k = 0; k < 16; k++) begin
      logic r, s, pw, ps, ewp, epv;
      r = k[0]; s = k[1]; pw = k[2]; ps = k[3];
      ewp = !r && pw; epv = !s && ps;
      access(32'h0000_2000, r, s, pw, ps, 8'h00, b, rd, sl);
      chk("R4/R5 berr", b, ewp || epv);
      chk("R4 wp flag", s_wp, ewp);
      chk("R5 priv flag", s_priv, epv);
      csr_wr(mdl(3'b110));
      chk("R7 flags cleared", {s_priv, s_wp}, 2'b00);
    end

    // R8 set beats clear on the same clock
    access(PRIM, 1'b0, 1'b1, 1'b1, 1'b0, mdl(3'b010), b, rd, sl);
    chk("R8 set wins", s_wp, 1);
    chk("R8 berr", b, 1);
    csr_wr(mdl(3'b010));
    chk("R8 cleared after", s_wp, 0);

    // R6 supervisor-only register protection
    m_so = 1;
    csr_wr(mdl(3'b000));
    access(PRIM, 1'b0, 1'b0, 1'b0, 1'b0, {1'b1, m_alias, m_so, m_ten, 4'b0000}, b, rd, sl);
    chk("R6 user write berr", b, 1);
    chk("R6 user write priv flag", s_priv, 1);
    chk("R6 user write ignored", w8, 0);
    m_priv = 1;
    csr_rd(rd);
    chk("R6 register unchanged", rd, mread());
    m_w8 = 1;
    csr_wr(mdl(3'b100));
    chk("R11 width8 set", w8, 1);
    chk("R6 priv cleared", s_priv, 0);
    m_so = 0;
    csr_wr(mdl(3'b000));
    access(PRIM, 1'b0, 1'b0, 1'b0, 1'b0, {1'b0, m_alias, 1'b0, m_ten, 4'b0000}, b, rd, sl);
    m_w8 = 0;
    chk("R6 user write allowed berr", b, 0);
    chk("R11 width8 cleared by user", w8, 0);

    // R10 reserved bit
    csr_wr(mdl(3'b000) | 8'h08);
    csr_rd(rd);
    chk("R10 reserved reads 0", rd[3], 0);
    chk("R10 full readback", rd, mread());

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule